// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Controller

This block models the command interpreter of a byte-wide parallel NOR flash that sits behind a cartridge bank mapper. The mapper turns a CPU write into a 19-bit flash address; its 16 KB banking lets the CPU reach the two unlock addresses (bank 1 with CPU offset $9555 gives flash $5555, bank 0 with $AAAA gives flash $2AAA). The controller watches every write strobe, recognises the unlock-and-command sequences for a single byte program and for a sector erase, and applies them to an internal storage array.

While an operation is in progress the block is busy: writes are ignored and every read returns a status byte whose bit 6 flips from one read to the next. Software therefore polls the target location until two consecutive reads return the same value, which is then the erased value $FF or the programmed data. Programming can only clear bits (the stored byte becomes old AND new); only an erase sets bits back to 1.

The storage array holds `2**MEM_AW` bytes and is indexed by the low `MEM_AW` address bits; the sector size is `2**SECT_W` bytes (4 KB by default). Command addresses are always compared on all 19 bits.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`) the sequence decoder is idle, `f_busy` is 0 and `f_rdata` is 8'h00; the array starts with every byte at 8'hFF.
- R2: A sequence starts only with data 8'hAA at address 19'h05555, followed by 8'h55 at 19'h02AAA; the compare uses all 19 address bits, so addresses that alias in the array do not unlock.
- R3: After the two unlock writes, 8'hA0 written to 19'h05555 arms a program; the next write stores (old byte AND written data) at array index `f_addr[MEM_AW-1:0]`.
- R4: The six-write sequence 8'hAA@05555, 8'h55@02AAA, 8'h80@05555, 8'hAA@05555, 8'h55@02AAA, 8'h30@any address erases to 8'hFF every byte whose index bits `[MEM_AW-1:SECT_W]` equal those of the last address; other sectors keep their contents.
- R5: A write with the wrong address or data at any step of a sequence returns the decoder to idle and has no effect; a later correct sequence still works.
- R6: `f_busy` rises on the clock edge that accepts the final write of a command and stays high for exactly `PROG_CYC` cycles after a program and max(`ERASE_CYC`, `2**SECT_W`) cycles after an erase.
- R7: Writes presented while `f_busy` is high are ignored: they neither change the array nor advance the decoder.
- R8: A read (`f_oe` high for one cycle) while not busy returns the array byte at `f_addr[MEM_AW-1:0]` on `f_rdata` one cycle later; `f_rdata` holds otherwise.
- R9: A read while busy returns a status byte with all bits except bit 6 at 0, and bit 6 differs between any two consecutive busy reads.
- R10: Polling the target location until two consecutive reads agree yields 8'hFF after an erase and the stored byte after a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_addr | input | 19 | Flash byte address from the mapper |
| f_wdata | input | 8 | Write data |
| f_we | input | 1 | Write strobe, one cycle per write |
| f_oe | input | 1 | Read strobe, one cycle per read |
| f_rdata | output | 8 | Read data or busy status, valid the cycle after a read |
| f_busy | output | 1 | High while a program or erase is in progress |

## Verification
The bench builds the block with `MEM_AW`=5, `SECT_W`=3, `PROG_CYC`=3 and `ERASE_CYC`=12, a 32-byte array of four 8-byte sectors. That size lets it program and read back every byte twice with different patterns, erase a sector and compare the whole array against an arithmetic model, and poll through busy periods short enough to see the status toggle on each read. The small index also makes the unlock addresses alias onto array bytes, which exposes any decoder that compares fewer than 19 bits, and lets every step of the program sequence be corrupted in turn.

// File: rtl/nor_pkg.sv
// Shared definitions for the NOR flash command controller.
// Assumes a 19-bit byte address and byte-wide data.
package nor_pkg;
    localparam int ADDR_W = 19;

    localparam logic [ADDR_W-1:0] UNLK_A1 = 19'h05555;
    localparam logic [ADDR_W-1:0] UNLK_A2 = 19'h02AAA;
    localparam logic [7:0] UNLK_D1   = 8'hAA;
    localparam logic [7:0] UNLK_D2   = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERSU  = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h30;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for first unlock
        S_UNL1,   // first unlock seen
        S_UNL2,   // both unlocks seen, expecting command
        S_PDATA,  // program armed, expecting target write
        S_EARM,   // erase setup seen
        S_EUNL1,  // erase: first repeat unlock seen
        S_EUNL2   // erase: second repeat unlock seen, expecting sector command
    } seq_state_t;
endpackage

// File: rtl/nor_seq_fsm.sv
// Command sequence decoder. Follows writes through the unlock, program
// and sector-erase sequences and pulses prog_go / erase_go in the cycle
// of the final write. Assumes the caller blocks writes while busy is high.
module nor_seq_fsm
    import nor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              prog_go,
    output logic              erase_go
);
    seq_state_t state, nxt;
    logic wr_ok, hit_u1, hit_u2;

    // decode the current write against the fixed unlock cycles
    always_comb begin
        wr_ok  = we && !busy;
        hit_u1 = (addr == UNLK_A1) && (wdata == UNLK_D1);
        hit_u2 = (addr == UNLK_A2) && (wdata == UNLK_D2);
    end

    // next-state and go-pulse logic; any mismatch falls back to idle
    always_comb begin
        nxt      = state;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        if (wr_ok) begin
            nxt = S_IDLE;
            unique case (state)
                S_IDLE:  if (hit_u1) nxt = S_UNL1;
                S_UNL1:  if (hit_u2) nxt = S_UNL2;
                S_UNL2: begin
                    if (addr == UNLK_A1 && wdata == CMD_PROG) nxt = S_PDATA;
                    else if (addr == UNLK_A1 && wdata == CMD_ERSU) nxt = S_EARM;
                end
                S_PDATA: prog_go = 1'b1;
                S_EARM:  if (hit_u1) nxt = S_EUNL1;
                S_EUNL1: if (hit_u2) nxt = S_EUNL2;
                S_EUNL2: erase_go = (wdata == CMD_SECT);
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !(we && !busy && addr == UNLK_A1 && wdata == UNLK_D1))
        |=> state == S_IDLE);
    // R5
    bad_unlock2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !busy && state == S_UNL1 && addr != UNLK_A2) |=> state == S_IDLE);
    // R7
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(state));
endmodule

// File: rtl/nor_busy_timer.sv
// Busy timer. Loads a cycle count when a command is accepted and runs the
// erase sweep index across one sector. Assumes 1 <= PROG_CYC <= erase length.
module nor_busy_timer #(
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 5000,
    parameter int SECT_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    output logic              busy,
    output logic              sweep_en,
    output logic [SECT_W-1:0] sweep_idx
);
    localparam int SECT_BYTES = 1 << SECT_W;
    localparam int ERASE_LEN  = (ERASE_CYC > SECT_BYTES) ? ERASE_CYC : SECT_BYTES;
    localparam int CNT_W      = $clog2(ERASE_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic             erasing;

    // count down the busy window and step the sweep during an erase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            erasing   <= 1'b0;
            sweep_idx <= '0;
        end else if (prog_go) begin
            cnt <= CNT_W'(PROG_CYC);
        end else if (erase_go) begin
            cnt       <= CNT_W'(ERASE_LEN);
            erasing   <= 1'b1;
            sweep_idx <= '0;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (erasing) begin
                sweep_idx <= sweep_idx + 1'b1;
                if (sweep_idx == SECT_W'(SECT_BYTES - 1)) erasing <= 1'b0;
            end
        end
    end

    // expose state
    always_comb begin
        busy     = (cnt != '0);
        sweep_en = erasing;
    end

    // R7
    no_go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(prog_go || erase_go));
    // R6
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy);
    // R6
    erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (busy && sweep_en));
endmodule

// File: rtl/nor_array.sv
// Storage array and read path. Applies AND-programming, sweeps a latched
// sector to 8'hFF during erase, and returns a toggling status while busy.
// Assumes MEM_AW >= SECT_W and that reads and writes never coincide.
module nor_array #(
    parameter int MEM_AW = 12,
    parameter int SECT_W = 12,
    parameter int SW     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [SW-1:0]     sect_addr,
    input  logic [7:0]        wdata,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              sweep_en,
    input  logic [SECT_W-1:0] sweep_idx,
    input  logic              oe,
    input  logic              busy,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]        mem [DEPTH];
    logic [SW-1:0]     sect_q;
    logic              tgl;
    logic [MEM_AW-1:0] sweep_a;
    logic [7:0]        old_b;

    // flash content starts erased
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    end

    // address of the byte being erased in this cycle
    always_comb begin
        sweep_a = (MEM_AW'(sect_q) << SECT_W) | MEM_AW'(sweep_idx);
        old_b   = mem[mem_addr];
    end

    // array writes: program clears bits, the sweep sets them
    always @(posedge clk) begin
        if (prog_go)       mem[mem_addr] <= old_b & wdata;
        else if (sweep_en) mem[sweep_a]  <= 8'hFF;
    end

    // sector latch, status toggle and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q <= '0;
            tgl    <= 1'b0;
            rdata  <= 8'h00;
        end else begin
            if (erase_go) sect_q <= sect_addr;
            if (oe && busy) begin
                tgl   <= ~tgl;
                rdata <= {1'b0, ~tgl, 6'b0};
            end else if (oe) begin
                rdata <= old_b;
            end
        end
    end

    // R3
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> ((mem[$past(mem_addr)] & ~$past(old_b)) == 8'h00));
    // R4
    sweep_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |-> busy);
    // R9
    status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && busy) |=> ((rdata & 8'hBF) == 8'h00));
    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> $stable(rdata));
endmodule

// File: rtl/nor_cmd_ctrl.sv
// Top of the NOR flash command controller: decoder, busy timer and array.
// Assumes one-cycle write and read strobes that are never both high.
module nor_cmd_ctrl #(
    parameter int MEM_AW    = 12,
    parameter int SECT_W    = 12,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [18:0] f_addr,
    input  logic [7:0]  f_wdata,
    input  logic        f_we,
    input  logic        f_oe,
    output logic [7:0]  f_rdata,
    output logic        f_busy
);
    localparam int SW = (MEM_AW > SECT_W) ? (MEM_AW - SECT_W) : 1;

    logic              prog_go, erase_go, sweep_en;
    logic [SECT_W-1:0] sweep_idx;

    nor_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (f_we),
        .busy     (f_busy),
        .addr     (f_addr),
        .wdata    (f_wdata),
        .prog_go  (prog_go),
        .erase_go (erase_go)
    );

    nor_busy_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .SECT_W    (SECT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .busy      (f_busy),
        .sweep_en  (sweep_en),
        .sweep_idx (sweep_idx)
    );

    nor_array #(
        .MEM_AW (MEM_AW),
        .SECT_W (SECT_W),
        .SW     (SW)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (f_addr[MEM_AW-1:0]),
        .sect_addr (f_addr[SECT_W +: SW]),
        .wdata     (f_wdata),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .sweep_en  (sweep_en),
        .sweep_idx (sweep_idx),
        .oe        (f_oe),
        .busy      (f_busy),
        .rdata     (f_rdata)
    );
endmodule

// File: tb/tb_nor_cmd_ctrl.sv
// Bench for nor_cmd_ctrl with a 32-byte array of four 8-byte sectors.
module tb_nor_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW = 5, SECT_W = 3, PROG_CYC = 3, ERASE_CYC = 12;
    localparam int DEPTH = 1 << MEM_AW;
    localparam int ERASE_LEN = (ERASE_CYC > (1 << SECT_W)) ? ERASE_CYC : (1 << SECT_W);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [18:0] f_addr = '0;
    logic [7:0]  f_wdata = '0;
    logic f_we = 1'b0, f_oe = 1'b0;
    logic [7:0] f_rdata;
    logic f_busy;

    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_ctrl #(.MEM_AW(MEM_AW), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
    dut (.clk(clk), .rst_n(rst_n), .f_addr(f_addr), .f_wdata(f_wdata), .f_we(f_we),
         .f_oe(f_oe), .f_rdata(f_rdata), .f_busy(f_busy));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        f_we = 1'b1; f_addr = a; f_wdata = d;
        @(negedge clk);
        f_we = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v, output bit was_busy);
        was_busy = f_busy;
        f_oe = 1'b1; f_addr = a;
        @(negedge clk);
        f_oe = 1'b0;
        v = f_rdata;
    endtask

    task automatic prog_seq(input logic [18:0] a, input logic [7:0] d);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_seq(input logic [18:0] a);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(a, 8'h30);
    endtask

    // count busy cycles from the current falling edge
    task automatic busy_len(input int exp, input string req);
        int n = 0;
        while (f_busy && n < 1000) begin n++; @(negedge clk); end
        check(n == exp, req, n, exp);
    endtask

    // poll until two equal reads; check status reads and final value
    task automatic poll(input logic [18:0] a, input logic [7:0] exp, input string req);
        logic [7:0] prev, cur, last_st;
        bit b, have_st = 0;
        int n = 0;
        rd(a, prev, b);
        if (b) begin last_st = prev; have_st = 1; end
        forever begin
            rd(a, cur, b);
            n++;
            if (b) begin
                check((cur & 8'hBF) == 8'h00, "R9 status format", cur, 0);
                if (have_st) check(cur[6] != last_st[6], "R9 bit6 toggles", cur, last_st ^ 8'h40);
                last_st = cur; have_st = 1;
            end
            if (cur == prev || n > 100) break;
            prev = cur;
        end
        check(cur == exp, req, cur, exp);
    endtask

    task automatic check_all(input string req);
        logic [7:0] v; bit b;
        for (int i = 0; i < DEPTH; i++) begin
            rd(19'(i), v, b);
            check(v == model[i] && !b, req, v, model[i]);
        end
    endtask

    function automatic logic [7:0] pat1(int i); return 8'((i * 29 + 7) ^ 8'hA5); endfunction
    function automatic logic [7:0] pat2(int i); return 8'(i * 53 + 8'h3C); endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v; bit b;
        logic [18:0] ea;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(f_busy == 1'b0, "R1 busy after reset", f_busy, 0);
        check(f_rdata == 8'h00, "R1 rdata after reset", f_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 erased contents");

        // R3/R6/R10 program every byte, high address bits varied
        for (int i = 0; i < DEPTH; i++) begin
            prog_seq(19'(i) | (19'(i) << 13), pat1(i));
            model[i] = model[i] & pat1(i);
            if (i < 4) busy_len(PROG_CYC, "R6 program busy length");
            poll(19'(i), model[i], "R10 poll after program");
        end
        check_all("R3 first pattern");

        // R3 second pass must AND into existing bytes
        for (int i = 0; i < DEPTH; i++) begin
            prog_seq(19'(i) | 19'h40000, pat2(i));
            model[i] = model[i] & pat2(i);
            poll(19'(i), model[i], "R3 AND program");
        end
        check_all("R3 second pattern");

        // R4/R6 erase sector 2 via an address with offset 5 and high bits set
        ea = 19'h7F000 | 19'(2 << SECT_W) | 19'd5;
        erase_seq(ea);
        for (int i = 16; i < 24; i++) model[i] = 8'hFF;
        busy_len(ERASE_LEN, "R6 erase busy length");
        check_all("R4 sector erase");

        // R10 poll across an erase
        erase_seq(19'(1 << SECT_W));
        for (int i = 8; i < 16; i++) model[i] = 8'hFF;
        poll(19'(9), 8'hFF, "R10 poll after erase");
        check_all("R4 second erase");

        // R2 aliased unlock addresses must not unlock
        wr(19'h00015, 8'hAA); wr(19'h0000A, 8'h55); wr(19'h00015, 8'hA0); wr(19'd3, 8'h00);
        check(f_busy == 1'b0, "R2 alias no busy", f_busy, 0);
        rd(19'd3, v, b);
        check(v == model[3], "R2 alias no program", v, model[3]);

        // R5 corrupt each step of the program sequence
        for (int k = 0; k < 3; k++) begin
            wr(19'h05555, (k == 0) ? 8'hAB : 8'hAA);
            wr(19'h02AAA, (k == 1) ? 8'h54 : 8'h55);
            wr(19'h05555, (k == 2) ? 8'hA1 : 8'hA0);
            wr(19'd4, 8'h00);
            check(f_busy == 1'b0, "R5 abort no busy", f_busy, 0);
            rd(19'd4, v, b);
            check(v == model[4], "R5 abort no program", v, model[4]);
        end
        // R5 erase aborted at fifth write (wrong address)
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'd0, 8'h30);
        check(f_busy == 1'b0, "R5 erase abort no busy", f_busy, 0);
        check_all("R5 erase abort contents");
        // R5 recovery after abort
        prog_seq(19'd4, 8'h0F);
        model[4] = model[4] & 8'h0F;
        poll(19'd4, model[4], "R5 recovery program");

        // R7 writes during busy ignored
        prog_seq(19'd1, 8'hF0);
        model[1] = model[1] & 8'hF0;
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        check(f_busy == 1'b0, "R7 busy over", f_busy, 0);
        wr(19'd2, 8'h00);
        check(f_busy == 1'b0, "R7 no command from busy writes", f_busy, 0);
        check_all("R7 contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule